// File: doc/BRIEF.md
# Dual Timer Peripheral Wrapper

This block puts two independent down-counting timer channels behind one 4 KB register window and turns a single bus access into the right channel access. Each channel has its own tick-enable input, so the two channels can count at different rates from different timer clocks (1 MHz each by default, delivered as one-cycle enables). A bus master reads and writes each channel's registers in its own 32-byte slot. The top 32 bytes of the window return a fixed table of identification bytes. The integration-test words read as zero. Every other offset reads as zero and ignores writes.

The two channel interrupts are ORed into one combined line. The per-channel lines are also brought out. Error strobes flag accesses that hit no register, either inside a channel slot or elsewhere in the window. A testbench or a bus monitor can use them to check the decode. Reads are combinational from the word address and the register state. Writes take effect at the clock edge that samples them.

Top module: `dual_timer`

## Requirements
- R1: Byte offsets 0x00 to 0x1F select channel 0 and offsets 0x20 to 0x3F select channel 1 at the same relative register offset (offset minus 0x20). A write to one channel never changes the other.
- R2: A read of word k (k = 0..7) at byte offset 0xFE0 + 4k returns, in bits 7:0 with all upper bits zero, the k-th entry of the sequence 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1. A write there has no effect on what is read back.
- R3: Reads at 0xF00 and 0xF04 (integration-test words) return zero and raise no error strobe.
- R4: A read at any other offset that maps to no register returns zero. A write outside 0x00 to 0x3F changes no channel register.
- R5: irq_o is high in the cycle in which any bit of ch_irq_o is high. ch_irq_o[c] is high when channel c has a latched expiry and its interrupt-enable bit is set.
- R6: Channel c advances only on cycles in which tick_i[c] is high. A tick on one channel leaves the other channel's count unchanged.
- R7: ch_err_o[c] is high during an access to relative offset 0x1C of channel c. bus_err_o is high during an access that hits no channel slot, no ID word and no integration-test word.
- R8: Channel registers, by relative offset: 0x00 reload value (a write also loads the count; a read returns the full 32 bits); 0x04 current count (writes ignored); 0x08 control; 0x0C expiry clear (write); 0x10 raw expiry flag in bit 0; 0x14 expiry flag masked by interrupt enable; 0x18 reload value only (count untouched). Control bits: 0 single-shot, 1 wide (32-bit) count, 3:2 prescale, 5 interrupt enable, 6 periodic, 7 run. Control resets to 0x20.
- R9: Each prescaled step while running decrements a nonzero count. The step from 1 to 0 latches the expiry flag. A step at count 0 holds in single-shot mode, reloads the reload value in periodic mode, and wraps to the all-ones maximum of the current width when neither mode bit is set.
- R10: With the wide bit clear, the count is 16 bits: loads are truncated to bits 15:0, and the free-running wrap value is 0xFFFF.
- R11: Prescale 0 (or 3) steps on every tick, prescale 1 on every 16th tick and prescale 2 on every 256th tick, counting from the most recent control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 2 | Per-channel timer clock enables |
| sel_i | input | 1 | Access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Word address (byte offset bits 11:2) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Combined interrupt |
| ch_irq_o | output | 2 | Per-channel interrupts |
| ch_err_o | output | 2 | Unused offset inside a channel slot |
| bus_err_o | output | 1 | Access to an unmapped offset |

## Verification
Read data and both error strobes are combinational. The bench holds each read for part of a low clock phase and samples one time unit after driving it, with no clock edge in between. A register write, an expiry clear and a count step each land at the rising edge that sees the strobe or tick. Their results are therefore read back at the falling edge that follows. The expiry flag and both interrupt outputs change at the same edge as the step from 1 to 0. The bench counts ticks and compares counts after exactly 15/16 and 255/256 ticks for the prescale boundaries.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  typedef enum logic [2:0] {
    REG_LOAD   = 3'd0,
    REG_VALUE  = 3'd1,
    REG_CTRL   = 3'd2,
    REG_ICLR   = 3'd3,
    REG_RAW    = 3'd4,
    REG_MASK   = 3'd5,
    REG_BGLOAD = 3'd6,
    REG_NONE   = 3'd7
  } dt_reg_e;

  localparam int CB_ONESHOT  = 0;
  localparam int CB_WIDE     = 1;
  localparam int CB_PRE_LO   = 2;
  localparam int CB_IE       = 5;
  localparam int CB_PERIODIC = 6;
  localparam int CB_RUN      = 7;
  localparam logic [7:0] CTRL_RST = 8'h20;

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0:    return 8'h04;
      3'd1:    return 8'h18;
      3'd2:    return 8'h14;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/dtmr_decode.sv
module dtmr_decode #(
  parameter int AW  = 12,
  parameter int NCH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_i,
  input  logic [AW-1:2]   addr_i,
  output logic [NCH-1:0]  acc_o,
  output logic [2:0]      idx_o,
  output logic            id_hit_o,
  output logic [2:0]      id_idx_o,
  output logic            itest_hit_o,
  output logic            miss_o
);
  localparam int SLOT_W  = AW - 5;
  localparam int WORD_W  = AW - 2;
  localparam int ITEST_W = (1 << WORD_W) - 64;

  logic [SLOT_W-1:0] slot;
  assign slot = addr_i[AW-1:5];

  for (genvar c = 0; c < NCH; c++) begin : g_acc
    assign acc_o[c] = sel_i && (slot == SLOT_W'(c));
  end

  assign idx_o       = addr_i[4:2];
  assign id_idx_o    = addr_i[4:2];
  assign id_hit_o    = sel_i && (slot == {SLOT_W{1'b1}});
  assign itest_hit_o = sel_i && ((addr_i == WORD_W'(ITEST_W)) ||
                                 (addr_i == WORD_W'(ITEST_W + 1)));
  assign miss_o      = sel_i && !(|acc_o) && !id_hit_o && !itest_hit_o;

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acc_o, id_hit_o, itest_hit_o, miss_o})) else $error("decode overlap"); // R1
  AST_CH0_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o[0] |-> (addr_i < WORD_W'(8))) else $error("ch0 window"); // R1
  AST_SEL_NEEDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> (acc_o == '0 && !miss_o && !id_hit_o)) else $error("decode w/o sel"); // R7

endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
  import dtmr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          acc_i,
  input  logic          we_i,
  input  logic [2:0]    idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          err_o,
  output logic          irq_o
);
  localparam int PW = 8;

  logic [DW-1:0] limit_q, count_q, mask_cur, mask_new;
  logic [7:0]    ctrl_q;
  logic          raw_q;
  logic [PW-1:0] pre_q;
  logic          pre_done, run, step, expire;
  logic          wr_load, wr_bg, wr_ctrl, wr_clr;
  dt_reg_e       reg_e;

  assign reg_e   = dt_reg_e'(idx_i);
  assign wr_load = acc_i && we_i && reg_e == REG_LOAD;
  assign wr_bg   = acc_i && we_i && reg_e == REG_BGLOAD;
  assign wr_ctrl = acc_i && we_i && reg_e == REG_CTRL;
  assign wr_clr  = acc_i && we_i && reg_e == REG_ICLR;

  assign mask_cur = ctrl_q[CB_WIDE]  ? '1 : {{(DW-16){1'b0}}, 16'hFFFF};
  assign mask_new = wdata_i[CB_WIDE] ? '1 : {{(DW-16){1'b0}}, 16'hFFFF};

  always_comb begin
    case (ctrl_q[CB_PRE_LO+1:CB_PRE_LO])
      2'd1:    pre_done = (pre_q[3:0] == 4'hF);
      2'd2:    pre_done = (pre_q == 8'hFF);
      default: pre_done = 1'b1;
    endcase
  end

  assign run    = ctrl_q[CB_RUN];
  assign step   = tick_i && run && pre_done;
  assign expire = step && count_q == DW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_RST;
      limit_q <= '0;
      pre_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i[7:0];
      if (wr_load || wr_bg) limit_q <= wdata_i;
      if (wr_ctrl) pre_q <= '0;
      else if (tick_i && run) pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (wr_load) begin
      count_q <= wdata_i & mask_cur;
    end else if (wr_ctrl) begin
      count_q <= count_q & mask_new;
    end else if (step) begin
      if (count_q != '0)               count_q <= count_q - 1'b1;
      else if (ctrl_q[CB_ONESHOT])     count_q <= '0;
      else if (ctrl_q[CB_PERIODIC])    count_q <= limit_q & mask_cur;
      else                             count_q <= mask_cur;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      raw_q <= 1'b0;
    else if (expire)  raw_q <= 1'b1;
    else if (wr_clr)  raw_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (acc_i && !we_i) begin
      case (reg_e)
        REG_LOAD, REG_BGLOAD: rdata_o = limit_q;
        REG_VALUE:            rdata_o = count_q;
        REG_CTRL:             rdata_o = {{(DW-8){1'b0}}, ctrl_q};
        REG_RAW:              rdata_o = {{(DW-1){1'b0}}, raw_q};
        REG_MASK:             rdata_o = {{(DW-1){1'b0}}, raw_q & ctrl_q[CB_IE]};
        default:              rdata_o = '0;
      endcase
    end
  end

  assign err_o = acc_i && reg_e == REG_NONE;
  assign irq_o = raw_q && ctrl_q[CB_IE];

  AST_RAW_ON_EXPIRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> raw_q) else $error("expiry not latched"); // R9
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr && !expire) |=> !raw_q) else $error("clear ignored"); // R8
  AST_LIMIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_i && we_i) |=> $stable(limit_q)) else $error("limit changed"); // R4
  AST_ONESHOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && ctrl_q[CB_ONESHOT] && count_q == '0 && !(acc_i && we_i)) |=> count_q == '0)
    else $error("single-shot moved"); // R9
  AST_NARROW_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[CB_WIDE] |-> count_q[DW-1:16] == '0) else $error("narrow overflow"); // R10
  AST_IDLE_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !(acc_i && we_i)) |=> $stable(count_q)) else $error("count w/o tick"); // R6

endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dtmr_pkg::*;
#(
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int NCH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCH-1:0]  tick_i,
  input  logic            sel_i,
  input  logic            wr_i,
  input  logic [AW-1:2]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_o,
  output logic [NCH-1:0]  ch_irq_o,
  output logic [NCH-1:0]  ch_err_o,
  output logic            bus_err_o
);
  logic [NCH-1:0]         acc;
  logic [2:0]             idx, id_idx;
  logic                   id_hit, itest_hit, miss;
  logic [NCH-1:0][DW-1:0] ch_rd;

  dtmr_decode #(.AW(AW), .NCH(NCH)) i_decode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel_i),
    .addr_i      (addr_i),
    .acc_o       (acc),
    .idx_o       (idx),
    .id_hit_o    (id_hit),
    .id_idx_o    (id_idx),
    .itest_hit_o (itest_hit),
    .miss_o      (miss)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dtmr_channel #(.DW(DW)) i_channel (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i[c]),
      .acc_i   (acc[c]),
      .we_i    (wr_i),
      .idx_i   (idx),
      .wdata_i (wdata_i),
      .rdata_o (ch_rd[c]),
      .err_o   (ch_err_o[c]),
      .irq_o   (ch_irq_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++) rdata_o |= ch_rd[c];
    if (id_hit && !wr_i) rdata_o |= {{(DW-8){1'b0}}, id_byte(id_idx)};
  end

  assign irq_o     = |ch_irq_o;
  assign bus_err_o = miss;

  AST_IRQ_MERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_irq_o != '0) |-> irq_o) else $error("merged irq low"); // R5
  AST_ID_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_hit && !wr_i) |-> rdata_o[DW-1:8] == '0) else $error("id upper bits"); // R2
  AST_ITEST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (itest_hit && !wr_i) |-> (rdata_o == '0 && !bus_err_o)) else $error("itest read"); // R3
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss && !wr_i) |-> (rdata_o == '0 && ch_err_o == '0)) else $error("unmapped read"); // R4

endmodule

// File: tb/test_dual_timer.sv
module test_dual_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] C_RUN = 32'h80, C_PER = 32'h40, C_IE = 32'h20,
                          C_ONE = 32'h01, C_WIDE = 32'h02, C_D16 = 32'h04, C_D256 = 32'h08;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  tick = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [11:2] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  logic [1:0]  ch_irq, ch_err;
  logic        bus_err;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] rv;
  logic [1:0]  cerr;
  logic        berr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_timer i_dual_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sel_i(sel), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .ch_irq_o(ch_irq), .ch_err_o(ch_err), .bus_err_o(bus_err)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a[11:2]; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a[11:2];
    #1; rv = rdata; cerr = ch_err; berr = bus_err;
    sel = 1'b0;
  endtask

  task automatic give_ticks(input logic [1:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = m;
      @(negedge clk); tick = '0;
    end
  endtask

  task automatic t_reset;
    bus_rd(12'h008); check("R8 ctrl reset", rv, 32'h20);
    bus_rd(12'h004); check("R8 count reset", rv, 0);
    check("R5 irq reset", {31'b0, irq}, 0);
  endtask

  task automatic t_periodic;
    bus_wr(12'h000, 3);
    bus_wr(12'h008, C_RUN | C_PER | C_IE | C_WIDE);
    give_ticks(2'b01, 2);
    bus_rd(12'h004); check("R9 periodic count", rv, 1);
    check("R5 irq before expiry", {31'b0, irq}, 0);
    give_ticks(2'b01, 1);
    bus_rd(12'h004); check("R9 periodic zero", rv, 0);
    bus_rd(12'h010); check("R9 raw set", rv, 1);
    check("R5 merged irq", {31'b0, irq}, 1);
    check("R5 ch irq", {30'b0, ch_irq}, 2'b01);
    give_ticks(2'b01, 1);
    bus_rd(12'h004); check("R9 periodic reload", rv, 3);
    bus_wr(12'h004, 32'h55);
    bus_rd(12'h004); check("R8 count write ignored", rv, 3);
    bus_wr(12'h018, 9);
    bus_rd(12'h004); check("R8 bgload keeps count", rv, 3);
    bus_rd(12'h000); check("R8 bgload sets reload", rv, 9);
    bus_wr(12'h00C, 0);
    bus_rd(12'h010); check("R8 clear raw", rv, 0);
    check("R5 irq after clear", {31'b0, irq}, 0);
    bus_wr(12'h008, C_IE);
  endtask

  task automatic t_oneshot;
    bus_wr(12'h020, 2);
    bus_wr(12'h028, C_RUN | C_ONE | C_IE | C_WIDE);
    give_ticks(2'b10, 2);
    bus_rd(12'h024); check("R9 oneshot zero", rv, 0);
    bus_rd(12'h030); check("R9 oneshot raw", rv, 1);
    give_ticks(2'b10, 3);
    bus_rd(12'h024); check("R9 oneshot hold", rv, 0);
    bus_wr(12'h02C, 0);
    bus_wr(12'h028, C_IE);
  endtask

  task automatic t_free16;
    bus_wr(12'h000, 32'h0001_2345);
    bus_rd(12'h000); check("R8 reload full width", rv, 32'h0001_2345);
    bus_rd(12'h004); check("R10 narrow load", rv, 32'h2345);
    bus_wr(12'h000, 1);
    bus_wr(12'h008, C_RUN | C_IE);
    give_ticks(2'b01, 1);
    bus_rd(12'h004); check("R9 free zero", rv, 0);
    give_ticks(2'b01, 1);
    bus_rd(12'h004); check("R10 free wrap 16", rv, 32'hFFFF);
    bus_wr(12'h00C, 0);
    bus_wr(12'h008, C_IE);
  endtask

  task automatic t_prescale;
    bus_wr(12'h000, 5);
    bus_wr(12'h008, C_RUN | C_PER | C_WIDE | C_D16);
    give_ticks(2'b01, 15);
    bus_rd(12'h004); check("R11 div16 before", rv, 5);
    give_ticks(2'b01, 1);
    bus_rd(12'h004); check("R11 div16 step", rv, 4);
    bus_wr(12'h000, 5);
    bus_wr(12'h008, C_RUN | C_PER | C_WIDE | C_D256);
    give_ticks(2'b01, 255);
    bus_rd(12'h004); check("R11 div256 before", rv, 5);
    give_ticks(2'b01, 1);
    bus_rd(12'h004); check("R11 div256 step", rv, 4);
    bus_wr(12'h008, C_IE);
  endtask

  task automatic t_mask;
    bus_wr(12'h020, 1);
    bus_wr(12'h028, C_RUN | C_PER | C_WIDE);
    give_ticks(2'b10, 1);
    bus_rd(12'h030); check("R8 raw w/o enable", rv, 1);
    bus_rd(12'h034); check("R8 masked w/o enable", rv, 0);
    check("R5 irq masked", {31'b0, irq}, 0);
    bus_wr(12'h028, C_IE | C_WIDE);
    bus_rd(12'h034); check("R8 masked with enable", rv, 1);
    check("R5 irq from ch1", {31'b0, irq}, 1);
    check("R5 ch1 line", {30'b0, ch_irq}, 2'b10);
    bus_wr(12'h02C, 0);
    check("R5 irq cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_independent;
    bus_wr(12'h000, 7);
    bus_wr(12'h020, 7);
    bus_wr(12'h008, C_RUN | C_PER | C_WIDE);
    bus_wr(12'h028, C_RUN | C_PER | C_WIDE);
    give_ticks(2'b10, 3);
    bus_rd(12'h004); check("R6 ch0 untouched", rv, 7);
    bus_rd(12'h024); check("R6 ch1 counted", rv, 4);
    give_ticks(2'b01, 1);
    bus_rd(12'h004); check("R6 ch0 counted", rv, 6);
    bus_rd(12'h024); check("R6 ch1 untouched", rv, 4);
    bus_wr(12'h008, C_IE);
    bus_wr(12'h028, C_IE);
  endtask

  task automatic t_decode;
    bus_wr(12'h000, 32'h111);
    bus_wr(12'h020, 32'hABC);
    bus_rd(12'h000); check("R1 ch0 own slot", rv, 32'h111);
    bus_rd(12'h020); check("R1 ch1 slot", rv, 32'hABC);
    bus_rd(12'h024); check("R1 ch1 offset 4", rv, 32'hABC);
  endtask

  task automatic t_ids;
    logic [7:0] exp_id [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int k = 0; k < 8; k++) begin
      bus_rd(12'hFE0 + 12'(4 * k));
      check("R2 id byte", rv, {24'b0, exp_id[k]});
    end
    bus_wr(12'hFE0, 32'hFF);
    bus_rd(12'hFE0); check("R2 id after write", rv, 32'h04);
  endtask

  task automatic t_unmapped;
    bus_rd(12'hF00); check("R3 itest ctrl", rv, 0);
    check("R3 itest no err", {31'b0, berr}, 0);
    bus_rd(12'hF04); check("R3 itest out", rv, 0);
    bus_rd(12'h040); check("R4 read 0x40", rv, 0);
    check("R7 bus err 0x40", {31'b0, berr}, 1);
    bus_rd(12'h800); check("R4 read 0x800", rv, 0);
    bus_wr(12'h040, 32'hDEAD);
    bus_wr(12'h100, 32'hBEEF);
    bus_wr(12'hF00, 32'h1);
    bus_rd(12'h000); check("R4 ch0 reload kept", rv, 32'h111);
    bus_rd(12'h020); check("R4 ch1 reload kept", rv, 32'hABC);
    bus_rd(12'h01C); check("R7 ch0 err", {30'b0, cerr}, 2'b01);
    check("R4 ch0 hole zero", rv, 0);
    bus_rd(12'h03C); check("R7 ch1 err", {30'b0, cerr}, 2'b10);
    bus_rd(12'h000); check("R7 no err on reg", {29'b0, cerr, berr}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_periodic;
    t_oneshot;
    t_free16;
    t_prescale;
    t_mask;
    t_independent;
    t_decode;
    t_ids;
    t_unmapped;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule